// File: doc/BRIEF.md
# Storage Port Interrupt Status and Enable

This block holds the interrupt state of one port of a serial storage host controller. Abstract event pulses from the receive path latch bits in a 32-bit status register. Each event is a frame that arrived with its interrupt flag set and was copied to memory, or one of several error conditions. Software reads the status and clears bits by writing 1 to them. A 32-bit enable register chooses which latched sources drive the port interrupt line. A global interrupt enable input gates that line.

One status bit works differently. The unknown-frame bit cannot be written by software. A diagnostic flag sets at once when an unknown frame is detected. The unknown-frame status bit sets later, when that frame has been posted to memory. It clears only when software clears the diagnostic flag. Both registers and the diagnostic register are reached through a simple read/write bus. A read returns its data one cycle after the request.

Top module: `port_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and diagnostic registers read 0, `port_irq` is 0 and `reg_rvalid` is 0.
- R2: A pulse on `ev_pulse[i]` sets status bit i for i in {0,1,2,3,24,26,28,29,30}, whatever the enable bit holds. Pulses at any other position, bit 4 included, leave the status unchanged.
- R3: A write to the status register (offset 0x110) clears every bit at positions {0,1,2,3,24,26,28,29,30} whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event sets a status bit in the same cycle that a status write clears it, the bit ends up set. The same rule applies to the diagnostic flag and to the unknown-frame bit.
- R5: The enable register (offset 0x114) stores write data at positions {0,1,2,3,4,24,26,28,29,30}. Bit 31 and every other position always read 0.
- R6: `port_irq` is 1 exactly when `glb_ie` is 1 and some status bit and its matching enable bit are both 1.
- R7: Status bit 4 (unknown frame) sets on an `unk_posted` pulse. Writes to the status register do not change it.
- R8: The diagnostic flag (bit 26 of offset 0x130) sets on an `unk_detect` pulse. A write of 1 to that bit clears it. When the flag is cleared this way, status bit 4 clears on the same clock edge.
- R9: A read request returns `reg_rvalid`=1 on the next cycle, with `reg_rdata` holding the register value from the request cycle. A read of an unmapped offset returns 0.
- R10: An `unk_detect` pulse on its own does not set status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset within the port window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| ev_pulse | input | 32 | One-cycle event pulses, one per status position |
| unk_detect | input | 1 | Unknown frame detected |
| unk_posted | input | 1 | Unknown frame posted to memory |
| glb_ie | input | 1 | Global interrupt enable |
| port_irq | output | 1 | Port interrupt line |

## Verification
The bench builds the block with its default parameters: a 12-bit address and offsets 0x110, 0x114 and 0x130. With these values it can reach every implemented status and enable position, the read-only and reserved positions, an unmapped offset, and the diagnostic flag. It drives all-ones patterns into the write data and the event vector, so that every masked position is exercised in one step. It also drives same-cycle set and clear collisions, and the full detect, post and clear sequence for unknown frames.

// File: rtl/pirq_pkg.sv
// Shared constants for the port interrupt block: status bit positions,
// write masks and the register offsets inside the port window.
package pirq_pkg;
    localparam int unsigned REG_W       = 32;
    localparam int unsigned POS_REGFRM  = 0;
    localparam int unsigned POS_PIOSET  = 1;
    localparam int unsigned POS_DMASET  = 2;
    localparam int unsigned POS_SDBITS  = 3;
    localparam int unsigned POS_UNKFRM  = 4;
    localparam int unsigned POS_OVFL    = 24;
    localparam int unsigned POS_IFNF    = 26;
    localparam int unsigned POS_HBDAT   = 28;
    localparam int unsigned POS_HBFAT   = 29;
    localparam int unsigned POS_TFERR   = 30;
    localparam int unsigned DIAG_F_POS  = 26;

    // Positions that are latched by events and cleared by writing 1
    localparam logic [REG_W-1:0] W1C_MASK =
        (32'd1 << POS_REGFRM) | (32'd1 << POS_PIOSET) | (32'd1 << POS_DMASET) |
        (32'd1 << POS_SDBITS) | (32'd1 << POS_OVFL)   | (32'd1 << POS_IFNF)   |
        (32'd1 << POS_HBDAT)  | (32'd1 << POS_HBFAT)  | (32'd1 << POS_TFERR);
    // Positions of the enable register that software may write
    localparam logic [REG_W-1:0] EN_MASK = W1C_MASK | (32'd1 << POS_UNKFRM);

    localparam logic [11:0] OFS_ISTAT = 12'h110;
    localparam logic [11:0] OFS_IEN   = 12'h114;
    localparam logic [11:0] OFS_DIAG  = 12'h130;
endpackage

// File: rtl/pirq_stat_bit.sv
// One latched status bit, cleared by writing 1.
// Assumes set_i and clr_i are single-cycle qualified strobes. When both
// arrive in the same cycle, the set wins.
module pirq_stat_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Latch on set, drop on clear, and give the set priority
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q); // R4
    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i) |=> q); // R3
endmodule

// File: rtl/pirq_unk_track.sv
// Tracks unknown frames: the diagnostic flag sets on detection, and the
// unknown-frame status bit sets once the frame is posted to memory.
// The status bit is not writable. It clears only when software clears the
// diagnostic flag. Assumes the detect and post inputs are single-cycle pulses.
module pirq_unk_track (
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic posted_i,
    input  logic f_wclr_i,
    output logic f_o,
    output logic ufs_o
);
    logic f_sw_clear;

    // A software clear only counts when it takes the flag from 1 to 0
    always_comb f_sw_clear = f_o && f_wclr_i && !det_i;

    // Diagnostic flag: detection wins over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)        f_o <= 1'b0;
        else if (det_i)    f_o <= 1'b1;
        else if (f_wclr_i) f_o <= 1'b0;
    end

    // Unknown-frame status: set on post, follow the flag's software clear
    always_ff @(posedge clk) begin
        if (!rst_n)          ufs_o <= 1'b0;
        else if (posted_i)   ufs_o <= 1'b1;
        else if (f_sw_clear) ufs_o <= 1'b0;
    end

    AST_F_ON_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |=> f_o); // R8
    AST_UFS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ufs_o && !f_sw_clear) |=> ufs_o); // R7
    AST_UFS_NEEDS_POST: assert property (@(posedge clk) disable iff (!rst_n)
        (!ufs_o && !posted_i) |=> !ufs_o); // R10
endmodule

// File: rtl/pirq_rd_port.sv
// Registered read mux. It returns the addressed register one cycle after
// the request, and 0 for any unmapped offset.
// Assumes at most one read request per cycle.
module pirq_rd_port #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] A_ISTAT = 'h110,
    parameter logic [ADDR_W-1:0] A_IEN   = 'h114,
    parameter logic [ADDR_W-1:0] A_DIAG  = 'h130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] istat_i,
    input  logic [DATA_W-1:0] ien_i,
    input  logic [DATA_W-1:0] diag_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    logic [DATA_W-1:0] sel;

    // Pick the addressed register
    always_comb begin
        unique case (addr_i)
            A_ISTAT: sel = istat_i;
            A_IEN:   sel = ien_i;
            A_DIAG:  sel = diag_i;
            default: sel = '0;
        endcase
    end

    // Register the read result and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_i;
            if (rd_i) rdata_o <= sel;
        end
    end

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o); // R9
    AST_NO_SPURIOUS_RV: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o); // R9
endmodule

// File: rtl/port_irq_ctrl.sv
// Per-port interrupt status and enable registers with a single gated
// interrupt line. Assumes event inputs are single-cycle pulses from the
// receive path, and that the register bus issues at most one read or
// write per cycle.
module port_irq_ctrl
    import pirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT),
    parameter logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN),
    parameter logic [ADDR_W-1:0] A_DIAG  = ADDR_W'(OFS_DIAG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic [31:0]       ev_pulse,
    input  logic              unk_detect,
    input  logic              unk_posted,
    input  logic              glb_ie,
    output logic              port_irq
);
    localparam int unsigned W = REG_W;

    logic [W-1:0] istat;
    logic [W-1:0] ien;
    logic [W-1:0] diag;
    logic [W-1:0] st_clr;
    logic         wr_istat, wr_ien, wr_diag;
    logic         diag_f, ufs;

    // Decode the write strobes per register
    always_comb begin
        wr_istat = reg_wr && (reg_addr == A_ISTAT);
        wr_ien   = reg_wr && (reg_addr == A_IEN);
        wr_diag  = reg_wr && (reg_addr == A_DIAG);
        st_clr   = wr_istat ? (reg_wdata & W1C_MASK) : '0;
    end

    // Build the status bits: W1C cells, the unknown-frame tracker, reserved zeros
    for (genvar i = 0; i < W; i++) begin : g_stat
        if (W1C_MASK[i]) begin : g_w1c
            pirq_stat_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (ev_pulse[i]),
                .clr_i (st_clr[i]),
                .q     (istat[i])
            );
        end else if (i == POS_UNKFRM) begin : g_unk
            assign istat[i] = ufs;
        end else begin : g_rsvd
            assign istat[i] = 1'b0;
        end
    end

    pirq_unk_track u_unk (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_i    (unk_detect),
        .posted_i (unk_posted),
        .f_wclr_i (wr_diag && reg_wdata[DIAG_F_POS]),
        .f_o      (diag_f),
        .ufs_o    (ufs)
    );

    // Place the diagnostic flag at its read position
    always_comb begin
        diag             = '0;
        diag[DIAG_F_POS] = diag_f;
    end

    // Enable register: only the implemented positions hold data
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (wr_ien) ien <= reg_wdata & EN_MASK;
    end

    // Gate the combined enabled sources with the global enable
    always_comb port_irq = glb_ie && |(istat & ien);

    pirq_rd_port #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (W),
        .A_ISTAT (A_ISTAT),
        .A_IEN   (A_IEN),
        .A_DIAG  (A_DIAG)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (reg_rd),
        .addr_i   (reg_addr),
        .istat_i  (istat),
        .ien_i    (ien),
        .diag_i   (diag),
        .rdata_o  (reg_rdata),
        .rvalid_o (reg_rvalid)
    );

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        port_irq |-> glb_ie); // R6
    AST_EN_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ien |=> (ien == ($past(reg_wdata) & EN_MASK))); // R5
    AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[POS_TFERR] |=> istat[POS_TFERR]); // R2
endmodule

// File: tb/sim_port_irq_ctrl.sv
// Scoreboard bench: the driver step pushes expected read data, and a
// monitor pops and compares it when reg_rvalid shows up.
module sim_port_irq_ctrl;
    localparam logic [31:0] W1C  = 32'h7500_000F;
    localparam logic [31:0] ENM  = 32'h7500_001F;
    localparam logic [11:0] A_ST = 12'h110;
    localparam logic [11:0] A_EN = 12'h114;
    localparam logic [11:0] A_DG = 12'h130;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, unk_detect = 0, unk_posted = 0, glb_ie = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, ev_pulse = '0, reg_rdata;
    logic reg_rvalid, port_irq;

    int checks = 0, fails = 0;
    logic [31:0] m_st = '0, m_en = '0;
    logic m_f = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    port_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .ev_pulse(ev_pulse), .unk_detect(unk_detect),
        .unk_posted(unk_posted), .glb_ie(glb_ie), .port_irq(port_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        if (a == A_ST) return m_st;
        if (a == A_EN) return m_en;
        if (a == A_DG) return {5'd0, m_f, 26'd0};
        return 32'd0;
    endfunction

    // Monitor: compare each returned read against the queued expectation
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) chk("R9 unexpected rvalid", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    // Driver: one bus cycle, model update, and an interrupt line check
    task automatic step(input logic wr, input logic rd, input logic [11:0] a,
                        input logic [31:0] wd, input logic [31:0] ev,
                        input logic det, input logic post, input string tag);
        logic [31:0] clr, setv;
        logic fclr, ufsclr;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        ev_pulse = ev; unk_detect = det; unk_posted = post;
        if (rd) begin exp_q.push_back(model_rd(a)); tag_q.push_back(tag); end
        clr    = (wr && a == A_ST) ? (wd & W1C) : 32'd0;
        setv   = ev & W1C;
        fclr   = wr && a == A_DG && wd[26];
        ufsclr = m_f && fclr && !det;
        m_f    = det | (m_f & ~fclr);
        m_st   = (m_st & ~clr) | setv;
        m_st[4] = post ? 1'b1 : (ufsclr ? 1'b0 : m_st[4]);
        if (wr && a == A_EN) m_en = wd & ENM;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; ev_pulse = '0; unk_detect = 0; unk_posted = 0;
        chk("R6 irq", {31'd0, port_irq}, {31'd0, glb_ie && |(m_st & m_en)});
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(0, 1, a, 0, 0, 0, 0, tag);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rvalid", {31'd0, reg_rvalid}, 32'd0);
        chk("R1 irq", {31'd0, port_irq}, 32'd0);
        rd(A_ST, "R1 status"); rd(A_EN, "R1 enable"); rd(A_DG, "R1 diag");
        // R5: all ones into enable, only implemented positions hold
        step(1, 0, A_EN, 32'hFFFF_FFFF, 0, 0, 0, "");
        rd(A_EN, "R5 enable mask");
        step(1, 0, A_EN, 32'h0, 0, 0, 0, "");
        // R2: all events with enables off; bit 4 and reserved ignored
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, "");
        rd(A_ST, "R2 status set while disabled");
        // R6: gating by enable and global enable
        step(1, 0, A_EN, 32'h1, 0, 0, 0, "");
        glb_ie = 1; step(0, 0, 0, 0, 0, 0, 0, "");
        glb_ie = 0; step(0, 0, 0, 0, 0, 0, 0, "");
        glb_ie = 1;
        // R3: writing 0 keeps, writing 1 clears
        step(1, 0, A_ST, 32'h0, 0, 0, 0, "");
        rd(A_ST, "R3 write zero no effect");
        step(1, 0, A_ST, 32'h0000_0001, 0, 0, 0, "");
        rd(A_ST, "R3 bit0 cleared");
        // R4: set and clear of bit 1 in the same cycle
        step(1, 0, A_ST, 32'h0000_0002, 32'h0000_0002, 0, 0, "");
        rd(A_ST, "R4 set wins");
        step(1, 0, A_ST, 32'hFFFF_FFFF, 0, 0, 0, "");
        rd(A_ST, "R3 clear all");
        // R10 and R8: detection sets flag only
        step(1, 0, A_EN, 32'h10, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 1, 0, "");
        rd(A_DG, "R8 flag set on detect");
        rd(A_ST, "R10 detect alone");
        step(0, 0, 0, 0, 0, 0, 1, "");
        rd(A_ST, "R7 set on post");
        step(1, 0, A_ST, 32'hFFFF_FFFF, 0, 0, 0, "");
        rd(A_ST, "R7 not writable");
        // R4: detect in same cycle as flag clear keeps both
        step(1, 0, A_DG, 32'h0400_0000, 0, 1, 0, "");
        rd(A_DG, "R4 detect beats flag clear");
        rd(A_ST, "R4 ufs kept");
        step(1, 0, A_DG, 32'h0400_0000, 0, 0, 0, "");
        rd(A_DG, "R8 flag cleared");
        rd(A_ST, "R8 ufs follows flag clear");
        // R9: unmapped offset
        rd(12'h200, "R9 unmapped read");
        step(0, 0, 0, 0, 0, 0, 0, "");
        chk("R9 queue drained", exp_q.size(), 32'd0);
        report();
    end
endmodule